// File: doc/BRIEF.md
# NAND Flash Access Cycle Sequencer

This block runs one access cycle on a NAND flash device that sits on a static memory bus. It is clocked by the system bus clock. A caller presents a request: the access kind (command, address or data), read or write, a write byte and a bank number. The caller also presents six timing codes. The block then moves through three phases in order: setup, strobe and hold. During these phases it drives one chip enable, the command and address latch enables, the active-low write and read strobes and the data bus output enable. On reads it samples the flash data bus.

Each phase length comes from its own timing code, and most codes add one cycle to the value written. The write-only tristate interval is timed by a separate counter that starts with the access. An active-low wait input lengthens the strobe. When the access ends, the block raises a one-cycle done pulse, and the captured read byte stays on a port until the next read replaces it.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, busy and done are low, all four chip enables and both strobes are high (inactive), the command latch, the address latch and the output enable are low.
- R2: A request is accepted when req_valid is high and busy is low. Busy is high from the next cycle. For writes, the setup phase lasts set_code+1 cycles (1 to 256) with both strobes high. Throughout the access, the command latch is high only for kind 2'b00 (command) and the address latch is high only for kind 2'b01 (address). Kinds 2'b10 and 2'b11 are data.
- R3: For reads, the setup phase lasts max(set_code, L)+1 cycles. L is the low 4 bits of clr_code for a command, the low 4 bits of ar_code for an address, and the larger of the two for data. So the read strobe follows the latch enable by at least L+1 cycles.
- R4: In the strobe phase, we_n is low on writes and re_n is low on reads, never both together. The phase lasts wait_code+1 cycles plus one cycle for every strobe cycle in which wait_n is sampled low.
- R5: The hold phase lasts hold_code+1 cycles with both strobes high, and the chip enable, latch enables and write data stay driven. On the next cycle done is high for exactly one cycle and busy is low.
- R6: On writes, dout_oe is low for the first min(hiz_code, access length) busy cycles (0 to 255) and then high until the access ends, with dout equal to the write byte. On reads, dout_oe stays low and hiz_code has no effect.
- R7: On reads, rdata takes the value of rdata_in from the last strobe cycle and keeps it through later accesses until the next read.
- R8: During an access, only ce_n[bank] is low, for bank values 0 to 3. While idle, all chip enables are high.
- R9: The timing codes and the bank are latched at acceptance. Changing the inputs during an access does not change its phase lengths or its chip enable.
- R10: A request raised while busy is ignored. It does not change the running access, and it does not start a new access after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 00 command, 01 address, 10/11 data |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Byte to drive on writes |
| req_bank | input | 2 | Chip enable to use |
| clr_code | input | 8 | Command-latch to read-strobe delay code (low 4 bits used) |
| ar_code | input | 8 | Address-latch to read-strobe delay code (low 4 bits used) |
| hiz_code | input | 8 | Write tristate cycles |
| hold_code | input | 8 | Hold phase code |
| wait_code | input | 8 | Strobe phase code |
| set_code | input | 8 | Setup phase code |
| wait_n | input | 1 | Active-low wait, extends the strobe |
| rdata_in | input | 8 | Flash data bus input |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| ce_n | output | 4 | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| dout | output | 8 | Flash data bus output |
| dout_oe | output | 1 | Data bus output enable |

## Verification
The assertions check these properties on every cycle:
- At most one chip enable is low.
- The two strobes are never low together.
- A strobe cycle with wait low is followed by another strobe cycle.
- Done comes only as a single pulse at the end of an access.
- A request raised while busy leaves the latched bank unchanged.

Only the bench scenarios can show the exact phase lengths under each off-by-one encoding. The same holds for:
- the read setup stretch chosen from the two latch-to-strobe codes;
- the clamped tristate count;
- which byte is captured;
- the immunity of a running access to changed inputs.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;

   localparam logic [1:0] KIND_CMD  = 2'b00;
   localparam logic [1:0] KIND_ADDR = 2'b01;
endpackage

// File: rtl/nand_phase_ctr.sv
module nand_phase_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/nand_bank_dec.sv
module nand_bank_dec #(
   parameter int NBANK = 4,
   localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic          active,
   input  logic [BW-1:0] bank,
   output logic [NBANK-1:0] ce_n
);
   for (genvar b = 0; b < NBANK; b++) begin : g_ce
      assign ce_n[b] = !(active && (bank == BW'(b)));
   end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int TW    = 8,
   parameter int SW    = 4,
   parameter int NBANK = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_kind,
   input  logic          req_write,
   input  logic [DW-1:0] req_wdata,
   input  logic [1:0]    req_bank,
   input  logic [TW-1:0] clr_code,
   input  logic [TW-1:0] ar_code,
   input  logic [TW-1:0] hiz_code,
   input  logic [TW-1:0] hold_code,
   input  logic [TW-1:0] wait_code,
   input  logic [TW-1:0] set_code,
   input  logic          wait_n,
   input  logic [DW-1:0] rdata_in,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic [NBANK-1:0] ce_n,
   output logic          cle,
   output logic          ale,
   output logic          we_n,
   output logic          re_n,
   output logic [DW-1:0] dout,
   output logic          dout_oe
);
   localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

   if (SW > TW) begin : g_bad_sw
      $error("short code width exceeds timing code width");
   end
   if (NBANK != 4) begin : g_bad_bank
      $error("bank select port is 2 bits wide, NBANK must be 4");
   end

   phase_t          ph;
   logic [1:0]      lat_kind;
   logic            lat_wr;
   logic [DW-1:0]   lat_wdata;
   logic [BW-1:0]   lat_bank;
   logic [TW-1:0]   lat_wait, lat_hold;

   logic            accept;
   logic [SW-1:0]   lead_clr, lead_ar, lead;
   logic [TW-1:0]   setup_len;
   logic            m_load, m_dec, m_zero;
   logic [TW-1:0]   m_val;
   logic            h_zero;

   assign accept   = (ph == PH_IDLE) && req_valid;
   assign lead_clr = clr_code[SW-1:0];
   assign lead_ar  = ar_code[SW-1:0];

   always_comb begin
      if (req_write)
         lead = '0;
      else if (req_kind == KIND_CMD)
         lead = lead_clr;
      else if (req_kind == KIND_ADDR)
         lead = lead_ar;
      else
         lead = (lead_clr > lead_ar) ? lead_clr : lead_ar;
      setup_len = (TW'(lead) > set_code) ? TW'(lead) : set_code;
   end

   always_comb begin
      m_load = 1'b0;
      m_dec  = 1'b0;
      m_val  = '0;
      unique case (ph)
         PH_IDLE: begin
            m_load = accept;
            m_val  = setup_len;
         end
         PH_SETUP: begin
            m_load = m_zero;
            m_val  = lat_wait;
            m_dec  = !m_zero;
         end
         PH_STROBE: begin
            m_load = m_zero && wait_n;
            m_val  = lat_hold;
            m_dec  = wait_n;
         end
         default: m_dec = 1'b1;
      endcase
   end

   nand_phase_ctr #(.CW(TW)) i_main_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (m_load),
      .load_val (m_val),
      .dec      (m_dec),
      .zero     (m_zero)
   );

   nand_phase_ctr #(.CW(TW)) i_hiz_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (hiz_code),
      .dec      (busy),
      .zero     (h_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         done      <= 1'b0;
         rdata     <= '0;
         lat_kind  <= KIND_CMD;
         lat_wr    <= 1'b0;
         lat_wdata <= '0;
         lat_bank  <= '0;
         lat_wait  <= '0;
         lat_hold  <= '0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: if (accept) begin
               ph        <= PH_SETUP;
               lat_kind  <= req_kind;
               lat_wr    <= req_write;
               lat_wdata <= req_wdata;
               lat_bank  <= req_bank[BW-1:0];
               lat_wait  <= wait_code;
               lat_hold  <= hold_code;
            end
            PH_SETUP: if (m_zero) ph <= PH_STROBE;
            PH_STROBE: if (m_zero && wait_n) begin
               ph <= PH_HOLD;
               if (!lat_wr) rdata <= rdata_in;
            end
            default: if (m_zero) begin
               ph   <= PH_IDLE;
               done <= 1'b1;
            end
         endcase
      end
   end

   assign busy    = (ph != PH_IDLE);
   assign cle     = busy && (lat_kind == KIND_CMD);
   assign ale     = busy && (lat_kind == KIND_ADDR);
   assign we_n    = !((ph == PH_STROBE) && lat_wr);
   assign re_n    = !((ph == PH_STROBE) && !lat_wr);
   assign dout    = lat_wdata;
   assign dout_oe = busy && lat_wr && h_zero;

   nand_bank_dec #(.NBANK(NBANK)) i_bank_dec (
      .active (busy),
      .bank   (lat_bank),
      .ce_n   (ce_n)
   );

   // R8
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ce_n));
   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   // R4
   wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_STROBE && !wait_n) |=> (ph == PH_STROBE));
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(ph) == PH_HOLD));
   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(lat_bank));
endmodule

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;
   typedef struct packed {
      logic [1:0] kind;
      logic       wr;
      logic [1:0] bank;
      logic [7:0] clr;
      logic [7:0] ar;
      logic [7:0] hiz;
      logic [7:0] hold;
      logic [7:0] wt;
      logic [7:0] set;
      logic [7:0] wlow;
      logic [7:0] data;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 1'b1, 2'd0, 8'd0,  8'd0,    8'd0,   8'd2,   8'd3, 8'd0,   8'd0, 8'hA5},
      '{2'd1, 1'b1, 2'd1, 8'd5,  8'd9,    8'd3,   8'd0,   8'd0, 8'd2,   8'd0, 8'h3C},
      '{2'd2, 1'b1, 2'd2, 8'd0,  8'd0,    8'd20,  8'd1,   8'd1, 8'd1,   8'd2, 8'h77},
      '{2'd0, 1'b0, 2'd3, 8'd7,  8'd2,    8'd0,   8'd0,   8'd2, 8'd1,   8'd3, 8'h10},
      '{2'd1, 1'b0, 2'd0, 8'd15, 8'h1C,   8'd9,   8'd2,   8'd0, 8'd3,   8'd0, 8'h40},
      '{2'd2, 1'b0, 2'd1, 8'd4,  8'd6,    8'd0,   8'd0,   8'd1, 8'd2,   8'd2, 8'h80},
      '{2'd3, 1'b0, 2'd2, 8'd3,  8'd1,    8'd0,   8'd1,   8'd0, 8'd20,  8'd0, 8'hC0},
      '{2'd2, 1'b1, 2'd3, 8'd0,  8'd0,    8'hFF,  8'hFF,  8'd0, 8'hFF,  8'd1, 8'h5A}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic req_write = 1'b0;
   logic [7:0] req_wdata = '0;
   logic [1:0] req_bank = '0;
   logic [7:0] clr_code = '0, ar_code = '0, hiz_code = '0;
   logic [7:0] hold_code = '0, wait_code = '0, set_code = '0;
   logic wait_n = 1'b1;
   logic [7:0] rdata_in = '0;
   logic busy, done, cle, ale, we_n, re_n, dout_oe;
   logic [7:0] rdata, dout;
   logic [3:0] ce_n;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] last_rd = '0;

   always #10 clk = !clk;

   nand_cycle_seq i_nand_cycle_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_write(req_write), .req_wdata(req_wdata), .req_bank(req_bank),
      .clr_code(clr_code), .ar_code(ar_code), .hiz_code(hiz_code),
      .hold_code(hold_code), .wait_code(wait_code), .set_code(set_code),
      .wait_n(wait_n), .rdata_in(rdata_in), .busy(busy), .done(done),
      .rdata(rdata), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .dout(dout), .dout_oe(dout_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // mode 0 plain, 1 scramble inputs after acceptance (R9), 2 poke request while busy (R10)
   task automatic run_access(input vec_t v, input int mode);
      int n_set = 0, n_str = 0, n_hld = 0, n_hiz = 0, n_tot = 0;
      int bad_ce = 0, bad_lat = 0, bad_dat = 0, oe_rd = 0, guard = 0;
      int lead, exp_set, exp_str, exp_tot, exp_hiz;
      bit timeout = 0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = v.kind; req_write = v.wr; req_wdata = v.data;
      req_bank = v.bank; clr_code = v.clr; ar_code = v.ar; hiz_code = v.hiz;
      hold_code = v.hold; wait_code = v.wt; set_code = v.set;
      @(negedge clk);
      req_valid = 1'b0;
      if (mode == 1) begin
         clr_code = 8'hFF; ar_code = 8'hFF; hiz_code = 8'h00; hold_code = 8'h09;
         wait_code = 8'h09; set_code = 8'h09; req_bank = v.bank + 2'd1;
      end
      while (!done) begin
         if (busy) begin
            n_tot++;
            if (ce_n !== ~(4'b1 << v.bank)) bad_ce++;
            if (cle !== (v.kind == 2'd0) || ale !== (v.kind == 2'd1)) bad_lat++;
            if (!we_n || !re_n) begin
               n_str++;
               if ((v.wr && re_n !== 1'b1) || (!v.wr && we_n !== 1'b1)) bad_lat++;
               wait_n = (n_str <= int'(v.wlow)) ? 1'b0 : 1'b1;
               rdata_in = v.data + 8'(n_str);
            end else if (n_str == 0) n_set++;
            else begin
               n_hld++;
               wait_n = 1'b1;
            end
            if (v.wr && !dout_oe) n_hiz++;
            if (v.wr && dout_oe && dout !== v.data) bad_dat++;
            if (!v.wr && dout_oe) oe_rd++;
         end
         if (mode == 2 && n_tot == 2) begin
            req_valid = 1'b1; req_bank = v.bank + 2'd2; req_kind = 2'd0;
         end
         if (mode == 2 && n_tot == 3) req_valid = 1'b0;
         guard++;
         if (guard > 4000) begin timeout = 1; break; end
         @(negedge clk);
      end
      chk(!timeout, "watchdog", guard, 4000);
      lead = v.wr ? 0 : (v.kind == 2'd0) ? int'(v.clr[3:0]) :
             (v.kind == 2'd1) ? int'(v.ar[3:0]) : mx(int'(v.clr[3:0]), int'(v.ar[3:0]));
      exp_set = mx(int'(v.set), lead) + 1;
      exp_str = int'(v.wt) + 1 + int'(v.wlow);
      exp_tot = exp_set + exp_str + int'(v.hold) + 1;
      exp_hiz = v.wr ? ((int'(v.hiz) < exp_tot) ? int'(v.hiz) : exp_tot) : 0;
      chk(n_set == exp_set, v.wr ? "R2 setup" : "R3 read setup", n_set, exp_set);
      chk(n_str == exp_str, "R4 strobe", n_str, exp_str);
      chk(n_hld == int'(v.hold) + 1, "R5 hold", n_hld, int'(v.hold) + 1);
      chk(bad_ce == 0, "R8 chip enable", bad_ce, 0);
      chk(bad_lat == 0, "R2 latch enables", bad_lat, 0);
      chk(n_hiz == exp_hiz && bad_dat == 0 && oe_rd == 0, "R6 output enable",
          n_hiz + 1000 * (bad_dat + oe_rd), exp_hiz);
      chk(busy === 1'b0, "R5 busy at done", busy, 0);
      if (!v.wr) last_rd = v.data + 8'(exp_str);
      chk(rdata === last_rd, "R7 read capture", rdata, last_rd);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R5 single done", done + 2 * busy, 0);
      if (mode == 2) begin
         @(negedge clk);
         chk(busy === 1'b0 && ce_n === 4'hF, "R10 no late start", busy, 0);
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", busy + 2 * done, 0);
      chk(ce_n === 4'hF && we_n === 1'b1 && re_n === 1'b1, "R1 strobes", ce_n, 15);
      chk(cle === 1'b0 && ale === 1'b0 && dout_oe === 1'b0, "R1 latches", cle + ale + dout_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) run_access(VEC[i], 0);
      // R9 inputs changed mid-access do not alter it
      run_access(VEC[3], 1);
      run_access(VEC[1], 1);
      // R10 request while busy is ignored
      run_access(VEC[0], 2);
      run_access(VEC[5], 2);
      // R7 read byte survives a write access
      run_access(VEC[2], 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule